// File: doc/BRIEF.md
# Keyed Countdown Watchdog Timer

This block is a watchdog that software must service at regular intervals. A single-cycle control write carries a command bit (start or stop), an 8-bit start value and a 7-bit key. Once started, the counter loads the start value. It then steps down by one on a slow tick. The tick comes from a prescaler that divides the system clock by `TICK_DIV`, which is 131072 by default; at a 100 MHz clock that gives roughly 763 decrements per second. Issuing start again while the counter runs reloads it, so starting and servicing are the same operation.

Each control write must present a key that is the bitwise inverse of the key on the last accepted write. This protects against runaway code that keeps writing the same value. The first write after power-on may use any key. Writes with a wrong key are dropped. A non-maskable interrupt request is raised while the running count equals 1, which gives one tick period of warning. When the count expires to 0, a one-cycle chip reset request is produced and the watchdog stops.

Top module: `keyed_watchdog`

## Requirements
- R1: After synchronous reset the watchdog is stopped, the count reads 0, and both `nmi_req` and `chip_rst_req` are low.
- R2: The first control write after reset is accepted whatever its key.
- R3: Every later write is accepted only if `cfg_key` equals the last accepted key XOR 7'h7F. A rejected write changes neither the count, the run state nor the stored key.
- R4: An accepted write with `cfg_start`=1 loads `cfg_count`, sets the watchdog running and clears the prescaler. Thereafter the count decreases by one every `TICK_DIV` cycles, with the first decrement `TICK_DIV` cycles after the load edge.
- R5: An accepted start while running reloads the count and restarts the tick period (a kick).
- R6: An accepted write with `cfg_start`=0 stops the watchdog. The count then holds its value.
- R7: `nmi_req` is high exactly while the watchdog runs with a count of 1. A reload or a stop removes it.
- R8: When a tick arrives at a count of 1, the count becomes 0, the watchdog stops and `chip_rst_req` is high for exactly one cycle.
- R9: A start with a value of 0 expires on the first tick, as in R8.
- R10: While stopped, the count never changes without an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control write strobe, one cycle per write |
| cfg_start | input | 1 | Command: 1 = start/reload, 0 = stop |
| cfg_count | input | 8 | Start value loaded on an accepted start |
| cfg_key | input | 7 | Key that must invert the previous accepted key |
| cnt_value | output | 8 | Current countdown value |
| wd_active | output | 1 | Watchdog is running |
| nmi_req | output | 1 | Pre-expiry non-maskable interrupt request |
| chip_rst_req | output | 1 | One-cycle chip reset request on expiry |

## Verification
The bench aims at the key sequence. It repeats the previous key, sends random wrong keys, and sends a correct key right after a rejected one. A design that stores rejected keys would then refuse the correct write or accept a wrong one. Kicks are placed in the cycle where a tick is due and also mid-period. A design that let the tick win, or that did not clear the prescaler, would show the decrement one period early or late. Start values of 0 and 1 check that expiry comes on the first tick and that the interrupt is raised straight after the load. A reset request longer than one cycle, or a count that moves while stopped, also shows up in the per-cycle comparison.

// File: rtl/wd_pkg.sv
// Shared definitions for the keyed watchdog.
// Assumes: command bit encoding is fixed by the control write format.
package wd_pkg;
    typedef enum logic {
        WD_CMD_STOP  = 1'b0,
        WD_CMD_START = 1'b1
    } wd_cmd_e;
endpackage

// File: rtl/wd_prescaler.sv
// Divides the system clock into a one-cycle tick every DIV cycles.
// Assumes: DIV >= 2; clear has priority and restarts the full period.
module wd_prescaler #(
    parameter int DIV = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    output logic tick
);
    localparam int PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);
    localparam logic [PRE_W-1:0] ONE  = PRE_W'(1);

    logic [PRE_W-1:0] phase_q;

    assign tick = enable && (phase_q == LAST);

    // Advance the phase while enabled, wrap at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_q <= '0;
        end else if (enable) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + ONE;
        end
    end
endmodule

// File: rtl/wd_key_gate.sv
// Decides whether a control write carries a valid key and remembers it.
// Assumes: the first write after reset is always valid; later keys must be
// the bitwise inverse of the previously accepted key.
module wd_key_gate #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    output logic             accept
);
    localparam logic [KEY_W-1:0] FLIP = {KEY_W{1'b1}};

    logic             seeded_q;
    logic [KEY_W-1:0] key_q;
    logic             key_match;

    // Expected key is the complement of the stored one.
    always_comb begin
        key_match = (wr_key == (key_q ^ FLIP));
        accept    = wr_en && (!seeded_q || key_match);
    end

    // Store the key of each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seeded_q <= 1'b0;
            key_q    <= '0;
        end else if (accept) begin
            seeded_q <= 1'b1;
            key_q    <= wr_key;
        end
    end
endmodule

// File: rtl/wd_down_counter.sv
// Countdown core: load/stop from accepted writes, decrement on tick,
// pre-expiry interrupt at count 1, single-cycle expiry pulse.
// Assumes: load and halt are never high together; writes beat ticks.
module wd_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             halt,
    input  logic [CNT_W-1:0] start_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             warn,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;
    logic             active_q;
    logic             expire_q;
    logic             last_step;

    assign last_step = active_q && tick && (count_q <= ONE);

    // Count, run state and expiry pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            active_q <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (load) begin
                count_q  <= start_val;
                active_q <= 1'b1;
            end else if (halt) begin
                active_q <= 1'b0;
            end else if (last_step) begin
                count_q  <= '0;
                active_q <= 1'b0;
                expire_q <= 1'b1;
            end else if (active_q && tick) begin
                count_q  <= count_q - ONE;
            end
        end
    end

    // Warning is a decode of the running state at count 1.
    always_comb begin
        count  = count_q;
        active = active_q;
        warn   = active_q && (count_q == ONE);
        expire = expire_q;
    end
endmodule

// File: rtl/keyed_watchdog.sv
// Top of the keyed watchdog: key gate, prescaler and countdown core.
// Assumes: cfg_we is a single-cycle strobe in the clk domain.
module keyed_watchdog #(
    parameter int CNT_W    = 8,
    parameter int KEY_W    = 7,
    parameter int TICK_DIV = 131072
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_start,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [KEY_W-1:0] cfg_key,
    output logic [CNT_W-1:0] cnt_value,
    output logic             wd_active,
    output logic             nmi_req,
    output logic             chip_rst_req
);
    import wd_pkg::*;

    logic    key_ok;
    logic    tick;
    logic    do_load;
    logic    do_halt;
    wd_cmd_e cmd;

    // Decode the command of an accepted write.
    always_comb begin
        cmd     = wd_cmd_e'(cfg_start);
        do_load = key_ok && (cmd == WD_CMD_START);
        do_halt = key_ok && (cmd == WD_CMD_STOP);
    end

    wd_key_gate #(.KEY_W(KEY_W)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_key (cfg_key),
        .accept (key_ok)
    );

    wd_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (key_ok),
        .enable (wd_active),
        .tick   (tick)
    );

    wd_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .halt      (do_halt),
        .start_val (cfg_count),
        .tick      (tick),
        .count     (cnt_value),
        .active    (wd_active),
        .warn      (nmi_req),
        .expire    (chip_rst_req)
    );
endmodule

// File: rtl/wd_checker.sv
// Protocol checks for keyed_watchdog, attached with bind.
module wd_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_start,
    input logic [CNT_W-1:0] cfg_count,
    input logic             key_ok,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_value,
    input logic             wd_active,
    input logic             nmi_req,
    input logic             chip_rst_req
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_rejected_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !key_ok && !tick) |=> ($stable(cnt_value) && $stable(wd_active)));

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_ok && cfg_start) |=> (wd_active && cnt_value == $past(cfg_count)));

    assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_ok && !cfg_start) |=> (!wd_active && !nmi_req));

    assert_nmi_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (wd_active && cnt_value == ONE));

    assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req);

    assert_expire_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst_req) |-> (!wd_active && cnt_value == '0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_active && !key_ok) |=> $stable(cnt_value));
endmodule

bind keyed_watchdog wd_checker #(.CNT_W(CNT_W)) u_wd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_start    (cfg_start),
    .cfg_count    (cfg_count),
    .key_ok       (key_ok),
    .tick         (tick),
    .cnt_value    (cnt_value),
    .wd_active    (wd_active),
    .nmi_req      (nmi_req),
    .chip_rst_req (chip_rst_req)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_start = 1'b0;
    logic [7:0] cfg_count = '0;
    logic [6:0] cfg_key = '0;
    logic [7:0] cnt_value;
    logic       wd_active;
    logic       nmi_req;
    logic       chip_rst_req;

    int checks = 0;
    int fails  = 0;

    // Reference state derived from the requirements.
    logic       m_seeded = 1'b0;
    logic [6:0] m_key = '0;
    logic [7:0] m_cnt = '0;
    logic       m_run = 1'b0;
    logic       m_rst = 1'b0;
    int         m_pre = 0;

    always #2.5 clk = ~clk;

    keyed_watchdog #(.TICK_DIV(DIV)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
        .cfg_count(cfg_count), .cfg_key(cfg_key), .cnt_value(cnt_value),
        .wd_active(wd_active), .nmi_req(nmi_req), .chip_rst_req(chip_rst_req)
    );

    function automatic logic key_valid(logic seeded, logic [6:0] last, logic [6:0] k);
        return !seeded || (k == (last ^ 7'h7F));
    endfunction

    function automatic logic exp_nmi(logic run, logic [7:0] c);
        return run && (c == 8'd1);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic acc;
        acc = cfg_we && key_valid(m_seeded, m_key, cfg_key);
        m_rst = 1'b0;
        if (acc) begin
            m_seeded = 1'b1;
            m_key = cfg_key;
            m_pre = 0;
            if (cfg_start) begin
                m_cnt = cfg_count;
                m_run = 1'b1;
            end else begin
                m_run = 1'b0;
            end
        end else if (m_run) begin
            if (m_pre == DIV - 1) begin
                m_pre = 0;
                if (m_cnt <= 8'd1) begin
                    m_cnt = 8'd0;
                    m_run = 1'b0;
                    m_rst = 1'b1;
                end else begin
                    m_cnt = m_cnt - 8'd1;
                end
            end else begin
                m_pre++;
            end
        end
    endtask

    task automatic compare_all();
        check("R4 count", int'(cnt_value), int'(m_cnt));
        check("R6 running", int'(wd_active), int'(m_run));
        check("R7 nmi", int'(nmi_req), int'(exp_nmi(m_run, m_cnt)));
        check("R8 reset pulse", int'(chip_rst_req), int'(m_rst));
    endtask

    // One clock: drive at negedge, update model at posedge, compare after.
    task automatic step(logic we, logic st, logic [7:0] c, logic [6:0] k);
        @(negedge clk);
        cfg_we = we; cfg_start = st; cfg_count = c; cfg_key = k;
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'd0, 7'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 count", int'(cnt_value), 0);
        check("R1 running", int'(wd_active), 0);
        check("R1 nmi", int'(nmi_req), 0);
        check("R1 rst", int'(chip_rst_req), 0);

        // R2: first key arbitrary
        step(1'b1, 1'b1, 8'd3, 7'h2A);
        check("R2 first accepted", int'(wd_active), 1);
        idle(5);
        // R3: same key again is rejected, stop ignored
        held = cnt_value;
        step(1'b1, 1'b0, 8'd9, 7'h2A);
        check("R3 stop ignored", int'(wd_active), 1);
        check("R3 count kept", int'(cnt_value), int'(held));
        // R5: kick with inverted key mid-period
        step(1'b1, 1'b1, 8'd2, 7'h55);
        check("R5 kick reload", int'(cnt_value), 2);
        // R4: first decrement exactly DIV cycles after load
        idle(DIV - 1);
        check("R4 no early step", int'(cnt_value), 2);
        idle(1);
        check("R4 stepped", int'(cnt_value), 1);
        check("R7 nmi raised", int'(nmi_req), 1);
        idle(DIV);
        check("R8 expiry pulse", int'(chip_rst_req), 1);
        idle(1);
        check("R8 one cycle", int'(chip_rst_req), 0);
        // R9: start value 0 expires on first tick
        step(1'b1, 1'b1, 8'd0, 7'h2A);
        idle(DIV);
        check("R9 zero expiry", int'(chip_rst_req), 1);
        // R6/R10: stop holds count
        step(1'b1, 1'b1, 8'd1, 7'h55);
        check("R7 nmi on load 1", int'(nmi_req), 1);
        step(1'b1, 1'b1, 8'd40, 7'h2A);
        idle(DIV * 2);
        step(1'b1, 1'b0, 8'd0, 7'h55);
        held = cnt_value;
        idle(DIV * 4);
        check("R10 held while stopped", int'(cnt_value), int'(held));
        check("R6 stopped", int'(wd_active), 0);

        // Random phase, including writes that land on a tick edge (R5).
        for (int i = 0; i < 6000; i++) begin
            int r;
            logic [6:0] k;
            r = int'($urandom_range(0, 99));
            k = m_seeded ? (m_key ^ 7'h7F) : 7'($urandom);
            if (r < 6) begin
                step(1'b1, ($urandom_range(0, 3) != 0), 8'($urandom_range(0, 5)), k);
            end else if (r < 9) begin
                step(1'b1, 1'($urandom), 8'($urandom_range(0, 5)),
                     k ^ 7'($urandom_range(1, 127)));
            end else if (r < 10 && m_run && m_pre == DIV - 1) begin
                step(1'b1, 1'b1, 8'd3, k);
            end else begin
                step(1'b0, 1'b0, 8'd0, 7'd0);
            end
        end
        finish_run();
    end
endmodule